// File: doc/BRIEF.md
# Framed Serial Channel Transmitter

This block is a transmit-only serial master. It takes six 16-bit two's complement channel words in one parallel load: three voltage channel words followed by three current channel words. It shifts them out one bit at a time on a data line. The block generates the bit clock from the master clock and raises a frame-start marker during the first bit of every frame. Each frame is 96 bits long.

A one-cycle load strobe copies the parallel words into a holding register. If the port is idle, a frame starts on the next master-clock edge. If a frame is already in progress, the request is held and the next frame follows the last bit of the current one with no gap. The rate-select input picks a bit clock of the master clock divided by 8 (low) or by 4 (high). It is sampled once at the start of each frame.

All three serial outputs are driven only while the output-enable input is high. When it is low they float, and the internal engine keeps running.

Top module: `frame_serial_tx`

## Requirements
- R1: A frame is 96 bits. The bits go out from `load_words[95]` down to `load_words[0]`, so word 0 (bits 95:80, first voltage channel) is sent first and each word is sent MSB first.
- R2: `fso` is high for exactly the first bit period of each frame and low during the other 95 bits.
- R3: `sdo` changes only while `sclk` is low, when a bit period begins. It holds its value from the rising edge of `sclk` until the next falling edge.
- R4: `sclk` has a period of 8 master-clock cycles when `rate_fast` was 0 at frame start, and 4 cycles when it was 1. The clock is low for the first half of each bit and high for the second half.
- R5: `rate_fast` is sampled only when a frame starts. Changing it mid-frame does not alter that frame's bit period.
- R6: Between frames `sclk` and `fso` are held low.
- R7: A load strobe during a frame captures new words. The next frame begins straight after the current one, with its first rising `sclk` edge one bit period after the last rising edge of the previous frame and `fso` high for its first bit.
- R8: While `out_en` is 0, `sclk`, `sdo` and `fso` are high-impedance. While `out_en` is 1, they are driven.
- R9: After reset the port is idle, with no pending frame and `sclk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_fast | input | 1 | Bit clock select: 0 = clk/8, 1 = clk/4 |
| out_en | input | 1 | Drive enable for the three serial outputs |
| load_stb | input | 1 | One-cycle request to send `load_words` |
| load_words | input | 96 | Six 16-bit words, word 0 in bits 95:80 |
| sclk | output | 1 | Generated bit clock, tri-state |
| sdo | output | 1 | Serial data, tri-state |
| fso | output | 1 | Frame-start marker, tri-state, tri-state |

## Verification
The assertions assume that `rate_fast` affects timing only through its value latched at frame start. They also assume that a strobe during a frame is a request for the next frame, not a restart. The stimulus therefore drives every strobe and every rate change on the falling master-clock edge. It moves `rate_fast` mid-frame only in the test that checks it is ignored. The bench reads the tri-state outputs through pull-ups, so a floating line reads 1 where a driven idle line reads 0. The bench never issues a second strobe while one is still pending.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
package frame_tx_pkg;

   // Counter width for a range of n values, never below one bit.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/frame_tx_timer.sv
`timescale 1ns/1ps
// Bit-period timer: low half then high half of the bit clock.
module frame_tx_timer
   import frame_tx_pkg::*;
#(
   parameter int unsigned DIV_SLOW = 8,
   parameter int unsigned DIV_FAST = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic fast,
   output logic bclk,
   output logic bit_end
);
   localparam int unsigned DIV_MAX = max2(DIV_SLOW, DIV_FAST);
   localparam int unsigned CW      = cnt_width(DIV_MAX);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] div_m1;
   logic [CW-1:0] half;

   generate
      if (DIV_SLOW == DIV_FAST) begin : g_single_rate
         assign div_m1 = CW'(DIV_SLOW - 1);
         assign half   = CW'(DIV_SLOW / 2);
      end else begin : g_dual_rate
         assign div_m1 = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
         assign half   = fast ? CW'(DIV_FAST / 2) : CW'(DIV_SLOW / 2);
      end
   endgenerate

   assign bit_end = busy && (cnt_q == div_m1);
   assign bclk    = busy && (cnt_q >= half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= '0;
      end else if (busy) begin
         cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      end
   end

   assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= div_m1));

endmodule

// File: rtl/frame_tx_shifter.sv
`timescale 1ns/1ps
// Frame shift engine: holds the frame, counts bits, marks the first one.
module frame_tx_shifter
   import frame_tx_pkg::*;
#(
   parameter int unsigned TOTAL_BITS = 96
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [TOTAL_BITS-1:0] frame_data,
   input  logic                  bit_end,
   output logic                  busy,
   output logic                  sdo,
   output logic                  fso,
   output logic                  last_bit
);
   localparam int unsigned IW = cnt_width(TOTAL_BITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL_BITS - 1);

   logic [TOTAL_BITS-1:0] shreg_q;
   logic [IW-1:0]         idx_q;

   assign sdo      = shreg_q[TOTAL_BITS-1];
   assign fso      = busy && (idx_q == '0);
   assign last_bit = (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         shreg_q <= '0;
         idx_q   <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         shreg_q <= frame_data;
         idx_q   <= '0;
      end else if (bit_end) begin
         if (last_bit) begin
            busy <= 1'b0;
         end else begin
            idx_q   <= idx_q + 1'b1;
            shreg_q <= {shreg_q[TOTAL_BITS-2:0], 1'b0};
         end
      end
   end

   assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx_q <= LAST_IDX));

   assert_frame_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && !start && !last_bit) |=> (sdo == $past(shreg_q[TOTAL_BITS-2])));

endmodule

// File: rtl/frame_serial_tx.sv
`timescale 1ns/1ps
// Framed serial transmitter: request latch, rate latch and tri-state edge.
module frame_serial_tx
   import frame_tx_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NUM_WORDS = 6,
   parameter int unsigned DIV_SLOW  = 8,
   parameter int unsigned DIV_FAST  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rate_fast,
   input  logic                          out_en,
   input  logic                          load_stb,
   input  logic [WORD_W*NUM_WORDS-1:0]   load_words,
   output logic                          sclk,
   output logic                          sdo,
   output logic                          fso
);
   localparam int unsigned TOTAL_BITS = WORD_W * NUM_WORDS;
   localparam int unsigned RUN_W      = cnt_width(max2(DIV_SLOW, DIV_FAST)) + 1;

   generate
      if (WORD_W < 1 || NUM_WORDS < 1 || TOTAL_BITS < 2) begin : g_bad_frame
         $error("frame_serial_tx: frame must hold at least two bits");
      end
      if (DIV_SLOW < 2 || DIV_FAST < 2 || (DIV_SLOW % 2) != 0 || (DIV_FAST % 2) != 0)
      begin : g_bad_div
         $error("frame_serial_tx: clock dividers must be even and at least 2");
      end
   endgenerate

   logic [TOTAL_BITS-1:0] hold_q;
   logic                  pend_q;
   logic                  rate_q;
   logic                  busy;
   logic                  bclk_int;
   logic                  sdo_int;
   logic                  fso_int;
   logic                  bit_end;
   logic                  last_bit;
   logic                  start;

   assign start = pend_q && (!busy || (bit_end && last_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         pend_q <= 1'b0;
         rate_q <= 1'b0;
      end else begin
         if (load_stb) hold_q <= load_words;
         pend_q <= load_stb || (pend_q && !start);
         if (start) rate_q <= rate_fast;
      end
   end

   frame_tx_timer #(
      .DIV_SLOW (DIV_SLOW),
      .DIV_FAST (DIV_FAST)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (busy),
      .fast    (rate_q),
      .bclk    (bclk_int),
      .bit_end (bit_end)
   );

   frame_tx_shifter #(
      .TOTAL_BITS (TOTAL_BITS)
   ) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .frame_data (hold_q),
      .bit_end    (bit_end),
      .busy       (busy),
      .sdo        (sdo_int),
      .fso        (fso_int),
      .last_bit   (last_bit)
   );

   assign sclk = out_en ? bclk_int : 1'bz;
   assign sdo  = out_en ? sdo_int  : 1'bz;
   assign fso  = out_en ? fso_int  : 1'bz;

   // Length of the current run of frame-start cycles.
   logic [RUN_W-1:0] fso_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fso_run_q <= '0;
      else if (fso_int) fso_run_q <= fso_run_q + 1'b1;
      else              fso_run_q <= '0;
   end

   assert_fso_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fso_run_q <= RUN_W'(max2(DIV_SLOW, DIV_FAST)));

   assert_sdo_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk_int) |-> $stable(sdo_int));

   assert_rate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> $stable(rate_q));

   assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bclk_int && !fso_int));

   assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_end && last_bit && pend_q) |=> (busy && fso_int && !bclk_int));

endmodule

// File: tb/frame_serial_tx_tb.sv
`timescale 1ns/1ps
module frame_serial_tx_tb;
   localparam int TCLK = 8;
   localparam int NB   = 96;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rate_fast = 1'b0;
   logic          out_en = 1'b1;
   logic          load_stb = 1'b0;
   logic [NB-1:0] load_words = '0;
   wire           sclk_w;
   wire           sdo_w;
   wire           fso_w;

   pullup (sclk_w);
   pullup (sdo_w);
   pullup (fso_w);

   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   time  last_rise = 0;

   always #(TCLK/2) clk = ~clk;

   frame_serial_tx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_fast  (rate_fast),
      .out_en     (out_en),
      .load_stb   (load_stb),
      .load_words (load_words),
      .sclk       (sclk_w),
      .sdo        (sdo_w),
      .fso        (fso_w)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic pulse_load(input logic [NB-1:0] d);
      @(negedge clk);
      load_words = d;
      load_stb   = 1'b1;
      @(negedge clk);
      load_stb   = 1'b0;
   endtask

   // Capture one frame on rising sclk; check data, marker, stability, period.
   task automatic capture(input logic [NB-1:0] exp, input int div, input bit gap_chk,
                          input string tag);
      logic [NB-1:0] got = '0;
      bit fso_ok = 1'b1, stab_ok = 1'b1, per_ok = 1'b1;
      for (int k = 0; k < NB; k++) begin
         time t;
         logic b, f;
         @(posedge sclk_w);
         t = $time;
         if ((k > 0 || gap_chk) && (t - last_rise != time'(div*TCLK))) per_ok = 1'b0;
         last_rise = t;
         #1;
         b = sdo_w;
         f = fso_w;
         got[NB-1-k] = b;
         if (f !== (k == 0)) fso_ok = 1'b0;
         #(div*TCLK/2 - 2);
         if (sdo_w !== b) stab_ok = 1'b0;
      end
      chk(got === exp, "R1", {tag, " frame bits"}, got, exp);
      chk(fso_ok, "R2", {tag, " fso only on first bit"}, NB'(fso_ok), NB'(1));
      chk(stab_ok, "R3", {tag, " sdo stable while sclk high"}, NB'(stab_ok), NB'(1));
      chk(per_ok, gap_chk ? "R7" : "R4", {tag, " bit period"}, NB'(per_ok), NB'(1));
   endtask

   task automatic check_idle(input int cycles, input string tag);
      bit ok = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (sclk_w !== 1'b0 || fso_w !== 1'b0) ok = 1'b0;
      end
      chk(ok, "R6", {tag, " sclk/fso low when idle"}, NB'(ok), NB'(1));
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(sclk_w === 1'b0, "R9", "sclk low in reset", NB'(sclk_w), NB'(0));
      rst_n = 1'b1;
      check_idle(30, "R9 after reset");
   endtask

   task automatic test_hiz();
      out_en = 1'b0;
      @(negedge clk);
      chk({sclk_w, sdo_w, fso_w} === 3'b111, "R8", "outputs float when disabled",
          NB'({sclk_w, sdo_w, fso_w}), NB'(3'b111));
      pulse_load(96'hFFFF_FFFF_FFFF_0000_0000_0000);
      begin
         bit ok = 1'b1;
         for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if ({sclk_w, sdo_w, fso_w} !== 3'b111) ok = 1'b0;
         end
         chk(ok, "R8", "outputs float during disabled frame", NB'(ok), NB'(1));
      end
      repeat (NB*8 + 20) @(negedge clk);
      out_en = 1'b1;
      @(negedge clk);
      chk({sclk_w, fso_w} === 2'b00, "R8", "outputs driven when enabled",
          NB'({sclk_w, fso_w}), NB'(0));
   endtask

   task automatic test_slow();
      logic [NB-1:0] d = 96'h8001_7FFF_0000_FFFF_1234_A5C3;
      rate_fast = 1'b0;
      pulse_load(d);
      capture(d, 8, 1'b0, "slow");
      check_idle(40, "slow");
   endtask

   task automatic test_fast();
      logic [NB-1:0] d = 96'h0F0F_C003_8000_0001_7E81_5A5A;
      rate_fast = 1'b1;
      pulse_load(d);
      capture(d, 4, 1'b0, "fast");
      check_idle(20, "fast");
   endtask

   task automatic test_chain();
      logic [NB-1:0] a = 96'hDEAD_BEEF_0123_4567_89AB_CDEF;
      logic [NB-1:0] b = 96'h1111_2222_3333_4444_5555_6666;
      rate_fast = 1'b0;
      pulse_load(a);
      fork
         begin
            capture(a, 8, 1'b0, "R7 first");
            capture(b, 8, 1'b1, "R7 second");
         end
         begin
            repeat (30) @(posedge sclk_w);
            pulse_load(b);
         end
      join
      check_idle(20, "chain");
   endtask

   task automatic test_rate_latch();
      logic [NB-1:0] d = 96'hA5A5_5A5A_FFFF_0000_C3C3_3C3C;
      rate_fast = 1'b0;
      pulse_load(d);
      fork
         capture(d, 8, 1'b0, "R5 rate changed mid-frame");
         begin
            repeat (10) @(posedge sclk_w);
            @(negedge clk);
            rate_fast = 1'b1;
         end
      join
      check_idle(10, "R5");
      pulse_load(~d);
      capture(~d, 4, 1'b0, "R5 next frame fast");
   endtask

   initial begin
      test_reset();
      test_hiz();
      test_slow();
      test_fast();
      test_chain();
      test_rate_latch();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule